// File: doc/BRIEF.md
# Exhaustive DES Key Search Engine

The engine recovers a DES key from one known block. It is handed a 64-bit plaintext, the 64-bit ciphertext that the secret key produces from it, and a closed range of 56-bit candidate keys given by a first and a last key. One pulse on the start input captures all of these values. The engine then encrypts the plaintext with each candidate in turn, in ascending order. It stops at the first candidate whose result equals the ciphertext, or after the last key of the range has failed.

The datapath is iterative. One Feistel round is computed per clock, with a key schedule register pair that rotates alongside it. A further cycle compares the result with the target, then either ends the search or loads the next candidate. A supervising controller starts the engine and polls four outputs: busy, found, exhausted, and the key register. After a search ends, these outputs hold their values until the next accepted start.

Top module: `des_key_search`

## Requirements
- R1: After reset, `busy_o`, `found_o` and `exhausted_o` are low and `key_o` is zero.
- R2: A 56-bit key is the 64-bit DES key with the lowest bit of every byte removed. Its seven-bit groups are packed from the most significant byte downwards, and the removed bits are never examined. With this packing, encryption matches standard DES known answers, for example key `12695BC9B7B7F8` takes `0123456789ABCDEF` to `85E813540F0AB405`.
- R3: Each candidate key costs exactly 17 cycles: 16 round cycles and one compare cycle. Counting the edge that accepts start as the first busy cycle, `busy_o` stays high for 17·N cycles when N candidates are tried.
- R4: Candidates are tried in ascending order, starting at the first key, each one greater than the last. The key counter is 56 bits wide, so after all ones it wraps to zero.
- R5: On the first candidate whose ciphertext equals the target, `found_o` goes high, `exhausted_o` stays low, `busy_o` falls, and `key_o` shows that candidate.
- R6: The last key of the range is itself tested. If it fails, `exhausted_o` goes high, `found_o` stays low, `busy_o` falls, and `key_o` shows the last key.
- R7: An accepted start raises `busy_o` and clears `found_o` and `exhausted_o` on the next cycle. After completion, the flags and `key_o` hold until the next accepted start.
- R8: A start pulse while `busy_o` is high is ignored, and the running search finishes with its original result.
- R9: Plaintext, ciphertext, first key and last key are sampled only at an accepted start. Changing them during a search has no effect on its outcome.
- R10: `found_o` and `exhausted_o` are never high together, and neither is high while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search; accepted only when idle |
| plain_i | input | 64 | Known plaintext block |
| cipher_i | input | 64 | Target ciphertext block |
| first_key_i | input | 56 | First candidate key (packed, no parity) |
| last_key_i | input | 56 | Last candidate key, inclusive |
| busy_o | output | 1 | Search in progress |
| found_o | output | 1 | Last search ended on a match |
| exhausted_o | output | 1 | Last search ended without a match |
| key_o | output | 56 | Current candidate; after completion, the matching or last key |

## Verification
The assertions assume that reset is released only between clock edges, and that a start request is a level sampled on the rising edge. They also assume that the key schedule and the round register are never loaded and stepped in the same cycle; the controller guarantees this. The stimulus changes the inputs and pulses start only on falling edges. It keeps every range to a handful of candidates, so each run is short. The one deliberate violation of the sampling rule, a start pulse with new data in the middle of a search, is aimed at R8 and R9 and must leave the outcome unchanged.

// File: rtl/des_search_pkg.sv
package des_search_pkg;

  localparam int KEY_W  = 56;
  localparam int BLK_W  = 64;
  localparam int HALF_W = BLK_W / 2;
  localparam int SUB_W  = 48;
  localparam int CD_W   = KEY_W / 2;
  localparam int ROUNDS = 16;
  localparam int RND_W  = $clog2(ROUNDS);
  localparam int N_SBOX = 8;

  typedef enum logic [1:0] {SRCH_IDLE, SRCH_RUN, SRCH_CHECK} srch_state_e;

  localparam int unsigned IP_T [64] = '{
    58, 50, 42, 34, 26, 18, 10, 2, 60, 52, 44, 36, 28, 20, 12, 4,
    62, 54, 46, 38, 30, 22, 14, 6, 64, 56, 48, 40, 32, 24, 16, 8,
    57, 49, 41, 33, 25, 17,  9, 1, 59, 51, 43, 35, 27, 19, 11, 3,
    61, 53, 45, 37, 29, 21, 13, 5, 63, 55, 47, 39, 31, 23, 15, 7};

  localparam int unsigned P_T [32] = '{
    16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
    2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};

  localparam int unsigned PC1_T [56] = '{
    57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
    10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
    14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};

  localparam int unsigned PC2_T [48] = '{
    14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
    23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // S-boxes, row-major: index = {row(2), column(4)}
  localparam int unsigned S1_T [64] = '{
    14, 4, 13, 1, 2, 15, 11, 8, 3, 10, 6, 12, 5, 9, 0, 7,
    0, 15, 7, 4, 14, 2, 13, 1, 10, 6, 12, 11, 9, 5, 3, 8,
    4, 1, 14, 8, 13, 6, 2, 11, 15, 12, 9, 7, 3, 10, 5, 0,
    15, 12, 8, 2, 4, 9, 1, 7, 5, 11, 3, 14, 10, 0, 6, 13};
  localparam int unsigned S2_T [64] = '{
    15, 1, 8, 14, 6, 11, 3, 4, 9, 7, 2, 13, 12, 0, 5, 10,
    3, 13, 4, 7, 15, 2, 8, 14, 12, 0, 1, 10, 6, 9, 11, 5,
    0, 14, 7, 11, 10, 4, 13, 1, 5, 8, 12, 6, 9, 3, 2, 15,
    13, 8, 10, 1, 3, 15, 4, 2, 11, 6, 7, 12, 0, 5, 14, 9};
  localparam int unsigned S3_T [64] = '{
    10, 0, 9, 14, 6, 3, 15, 5, 1, 13, 12, 7, 11, 4, 2, 8,
    13, 7, 0, 9, 3, 4, 6, 10, 2, 8, 5, 14, 12, 11, 15, 1,
    13, 6, 4, 9, 8, 15, 3, 0, 11, 1, 2, 12, 5, 10, 14, 7,
    1, 10, 13, 0, 6, 9, 8, 7, 4, 15, 14, 3, 11, 5, 2, 12};
  localparam int unsigned S4_T [64] = '{
    7, 13, 14, 3, 0, 6, 9, 10, 1, 2, 8, 5, 11, 12, 4, 15,
    13, 8, 11, 5, 6, 15, 0, 3, 4, 7, 2, 12, 1, 10, 14, 9,
    10, 6, 9, 0, 12, 11, 7, 13, 15, 1, 3, 14, 5, 2, 8, 4,
    3, 15, 0, 6, 10, 1, 13, 8, 9, 4, 5, 11, 12, 7, 2, 14};
  localparam int unsigned S5_T [64] = '{
    2, 12, 4, 1, 7, 10, 11, 6, 8, 5, 3, 15, 13, 0, 14, 9,
    14, 11, 2, 12, 4, 7, 13, 1, 5, 0, 15, 10, 3, 9, 8, 6,
    4, 2, 1, 11, 10, 13, 7, 8, 15, 9, 12, 5, 6, 3, 0, 14,
    11, 8, 12, 7, 1, 14, 2, 13, 6, 15, 0, 9, 10, 4, 5, 3};
  localparam int unsigned S6_T [64] = '{
    12, 1, 10, 15, 9, 2, 6, 8, 0, 13, 3, 4, 14, 7, 5, 11,
    10, 15, 4, 2, 7, 12, 9, 5, 6, 1, 13, 14, 0, 11, 3, 8,
    9, 14, 15, 5, 2, 8, 12, 3, 7, 0, 4, 10, 1, 13, 11, 6,
    4, 3, 2, 12, 9, 5, 15, 10, 11, 14, 1, 7, 6, 0, 8, 13};
  localparam int unsigned S7_T [64] = '{
    4, 11, 2, 14, 15, 0, 8, 13, 3, 12, 9, 7, 5, 10, 6, 1,
    13, 0, 11, 7, 4, 9, 1, 10, 14, 3, 5, 12, 2, 15, 8, 6,
    1, 4, 11, 13, 12, 3, 7, 14, 10, 15, 6, 8, 0, 5, 9, 2,
    6, 11, 13, 8, 1, 4, 10, 7, 9, 5, 0, 15, 14, 2, 3, 12};
  localparam int unsigned S8_T [64] = '{
    13, 2, 8, 4, 6, 15, 11, 1, 10, 9, 3, 14, 5, 0, 12, 7,
    1, 15, 13, 8, 10, 3, 7, 4, 12, 5, 6, 11, 0, 14, 9, 2,
    7, 11, 4, 1, 9, 12, 14, 2, 0, 6, 10, 13, 15, 3, 5, 8,
    2, 1, 14, 7, 4, 10, 8, 13, 15, 12, 9, 0, 3, 5, 6, 11};

  // Table entries are 1-based, counted from the MSB.
  function automatic logic [63:0] des_ip(input logic [63:0] x);
    logic [63:0] res;
    res = '0;
    for (int i = 0; i < 64; i++) res[6'(63 - i)] = x[6'(64 - IP_T[i])];
    return res;
  endfunction

  function automatic logic [63:0] des_fp(input logic [63:0] x);
    logic [63:0] res;
    res = '0;
    for (int i = 0; i < 64; i++) res[6'(64 - IP_T[i])] = x[6'(63 - i)];
    return res;
  endfunction

  function automatic logic [47:0] des_expand(input logic [31:0] r);
    logic [47:0] res;
    res = '0;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 6; k++)
        res[6'(47 - 6 * j - k)] = r[5'(31 - ((4 * j + k + 31) % 32))];
    return res;
  endfunction

  function automatic logic [31:0] des_pbox(input logic [31:0] x);
    logic [31:0] res;
    res = '0;
    for (int i = 0; i < 32; i++) res[5'(31 - i)] = x[5'(32 - P_T[i])];
    return res;
  endfunction

  // Reinsert a zero at the low bit of every byte.
  function automatic logic [63:0] key_widen(input logic [55:0] k);
    logic [63:0] res;
    res = '0;
    for (int i = 0; i < 64; i++)
      if (i % 8 != 7) res[6'(63 - i)] = k[6'(55 - ((i / 8) * 7 + (i % 8)))];
    return res;
  endfunction

  function automatic logic [55:0] des_pc1(input logic [55:0] k);
    logic [63:0] w;
    logic [55:0] res;
    w   = key_widen(k);
    res = '0;
    for (int i = 0; i < 56; i++) res[6'(55 - i)] = w[6'(64 - PC1_T[i])];
    return res;
  endfunction

  function automatic logic [47:0] des_pc2(input logic [55:0] cd);
    logic [47:0] res;
    res = '0;
    for (int i = 0; i < 48; i++) res[6'(47 - i)] = cd[6'(56 - PC2_T[i])];
    return res;
  endfunction

  function automatic logic [3:0] des_sbox(input int unsigned idx, input logic [5:0] b);
    logic [5:0] a;
    a = {b[5], b[0], b[4:1]};
    case (idx)
      0:       return 4'(S1_T[a]);
      1:       return 4'(S2_T[a]);
      2:       return 4'(S3_T[a]);
      3:       return 4'(S4_T[a]);
      4:       return 4'(S5_T[a]);
      5:       return 4'(S6_T[a]);
      6:       return 4'(S7_T[a]);
      default: return 4'(S8_T[a]);
    endcase
  endfunction

  // Rounds 1, 2, 9 and 16 (zero-based 0, 1, 8, 15) rotate by one bit.
  function automatic logic rot_single(input logic [RND_W-1:0] rnd);
    return (rnd == 4'd0) || (rnd == 4'd1) || (rnd == 4'd8) || (rnd == 4'd15);
  endfunction

endpackage

// File: rtl/des_f_func.sv
module des_f_func
  import des_search_pkg::*;
(
  input  logic [HALF_W-1:0] r_i,
  input  logic [SUB_W-1:0]  subkey_i,
  output logic [HALF_W-1:0] f_o
);

  logic [SUB_W-1:0]  mixed;
  logic [HALF_W-1:0] sub_out;

  assign mixed = des_expand(r_i) ^ subkey_i;

  for (genvar g = 0; g < N_SBOX; g++) begin : g_sbox
    assign sub_out[HALF_W-1-4*g -: 4] = des_sbox(g, mixed[SUB_W-1-6*g -: 6]);
  end

  assign f_o = des_pbox(sub_out);

endmodule

// File: rtl/des_key_sched.sv
module des_key_sched
  import des_search_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             step_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic [SUB_W-1:0] subkey_o
);

  logic [CD_W-1:0] c_q, d_q, c_nx, d_nx;

  always_comb begin
    if (rot_single(rnd_i)) begin
      c_nx = {c_q[CD_W-2:0], c_q[CD_W-1]};
      d_nx = {d_q[CD_W-2:0], d_q[CD_W-1]};
    end else begin
      c_nx = {c_q[CD_W-3:0], c_q[CD_W-1 -: 2]};
      d_nx = {d_q[CD_W-3:0], d_q[CD_W-1 -: 2]};
    end
  end

  assign subkey_o = des_pc2({c_nx, d_nx});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= '0;
      d_q <= '0;
    end else if (load_i) begin
      {c_q, d_q} <= des_pc1(key_i);
    end else if (step_i) begin
      c_q <= c_nx;
      d_q <= d_nx;
    end
  end

  assert_no_load_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));

endmodule

// File: rtl/des_round_core.sv
module des_round_core
  import des_search_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BLK_W-1:0] block_i,
  input  logic             step_i,
  input  logic [SUB_W-1:0] subkey_i,
  output logic [BLK_W-1:0] result_o
);

  logic [HALF_W-1:0] l_q, r_q, f_val;

  des_f_func u_f (
    .r_i      (r_q),
    .subkey_i (subkey_i),
    .f_o      (f_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q <= '0;
      r_q <= '0;
    end else if (load_i) begin
      {l_q, r_q} <= block_i;
    end else if (step_i) begin
      l_q <= r_q;
      r_q <= l_q ^ f_val;
    end
  end

  // halves swapped before the final permutation
  assign result_o = des_fp({r_q, l_q});

  assert_step_moves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> l_q == $past(r_q));

endmodule

// File: rtl/des_key_search.sv
module des_key_search
  import des_search_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] plain_i,
  input  logic [BLK_W-1:0] cipher_i,
  input  logic [KEY_W-1:0] first_key_i,
  input  logic [KEY_W-1:0] last_key_i,
  output logic             busy_o,
  output logic             found_o,
  output logic             exhausted_o,
  output logic [KEY_W-1:0] key_o
);

  srch_state_e      state_q;
  logic [RND_W-1:0] rnd_q;
  logic [KEY_W-1:0] key_q, last_q, key_nx;
  logic [BLK_W-1:0] tgt_q, ipblk_q, result, load_blk;
  logic             found_q, exh_q;
  logic             accept, hit, at_last, advance, load, step;

  assign accept   = start_i && (state_q == SRCH_IDLE);
  assign hit      = (state_q == SRCH_CHECK) && (result == tgt_q);
  assign at_last  = key_q == last_q;
  assign advance  = (state_q == SRCH_CHECK) && !hit && !at_last;
  assign load     = accept || advance;
  assign step     = state_q == SRCH_RUN;
  assign key_nx   = accept ? first_key_i : key_q + KEY_W'(1);
  assign load_blk = accept ? des_ip(plain_i) : ipblk_q;

  des_key_sched u_sched (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .key_i    (key_nx),
    .step_i   (step),
    .rnd_i    (rnd_q),
    .subkey_o (subkey)
  );

  logic [SUB_W-1:0] subkey;

  des_round_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .block_i  (load_blk),
    .step_i   (step),
    .subkey_i (subkey),
    .result_o (result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRCH_IDLE;
      rnd_q   <= '0;
      key_q   <= '0;
      last_q  <= '0;
      tgt_q   <= '0;
      ipblk_q <= '0;
      found_q <= 1'b0;
      exh_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SRCH_IDLE: if (accept) begin
          key_q   <= first_key_i;
          last_q  <= last_key_i;
          tgt_q   <= cipher_i;
          ipblk_q <= load_blk;
          found_q <= 1'b0;
          exh_q   <= 1'b0;
          rnd_q   <= '0;
          state_q <= SRCH_RUN;
        end
        SRCH_RUN: begin
          rnd_q <= rnd_q + RND_W'(1);
          if (rnd_q == RND_W'(ROUNDS - 1)) state_q <= SRCH_CHECK;
        end
        SRCH_CHECK: begin
          if (hit) begin
            found_q <= 1'b1;
            state_q <= SRCH_IDLE;
          end else if (at_last) begin
            exh_q   <= 1'b1;
            state_q <= SRCH_IDLE;
          end else begin
            key_q   <= key_nx;
            rnd_q   <= '0;
            state_q <= SRCH_RUN;
          end
        end
        default: state_q <= SRCH_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != SRCH_IDLE;
  assign found_o     = found_q;
  assign exhausted_o = exh_q;
  assign key_o       = key_q;

  assert_flags_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(found_q && exh_q));
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_q || exh_q) |-> !busy_o);
  assert_round_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SRCH_RUN && rnd_q == RND_W'(ROUNDS - 1)) |=> state_q == SRCH_CHECK);
  assert_key_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SRCH_CHECK && result != tgt_q && key_q != last_q)
      |=> key_q == $past(key_q) + KEY_W'(1));
  assert_match_key_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q |-> result == tgt_q);
  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(last_q) && $stable(tgt_q) && $stable(ipblk_q));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(found_q) && $stable(exh_q) && $stable(key_q));

endmodule

// File: tb/des_key_search_bench.sv
module des_key_search_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  RND_CYC    = 17;
  localparam int  WATCHDOG   = 200000;

  localparam logic [55:0] KEY_A = 56'h12695BC9B7B7F8;
  localparam logic [55:0] KEY_B = 56'h0E66499EAD8339;
  localparam logic [63:0] CT_ZERO = 64'h8CA64DE9C1B123A7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] plain = '0, cipher = '0;
  logic [55:0] first_key = '0, last_key = '0;
  logic        busy_o, found_o, exhausted_o;
  logic [55:0] key_o;

  typedef struct {
    logic        found;
    logic [55:0] key;
    int          cycles;
    string       req;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  des_key_search u_des_key_search (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .plain_i     (plain),
    .cipher_i    (cipher),
    .first_key_i (first_key),
    .last_key_i  (last_key),
    .busy_o      (busy_o),
    .found_o     (found_o),
    .exhausted_o (exhausted_o),
    .key_o       (key_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: count busy cycles, compare at the falling edge of busy
  int cyc = 0;
  bit prev_busy = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      prev_busy = 1'b0;
    end else begin
      if (busy_o) cyc++;
      if (prev_busy && !busy_o) begin
        if (sb_q.size() == 0) begin
          chk("R3 unexpected completion", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({e.req, " found"}, 64'(found_o), 64'(e.found));
          chk({e.req, " exhausted"}, 64'(exhausted_o), 64'(!e.found));
          chk({e.req, " key"}, 64'(key_o), 64'(e.key));
          chk("R3 busy cycles", 64'(cyc), 64'(e.cycles));
        end
        cyc = 0;
      end
      prev_busy = busy_o;
    end
  end

  task automatic run_search(input logic [63:0] pt, input logic [63:0] ct,
                            input logic [55:0] k_first, input logic [55:0] k_last,
                            input logic exp_found, input logic [55:0] exp_key,
                            input int n_cand, input string req, input bit disturb);
    exp_t e;
    e.found  = exp_found;
    e.key    = exp_key;
    e.cycles = RND_CYC * n_cand;
    e.req    = req;
    sb_q.push_back(e);
    @(negedge clk);
    plain = pt; cipher = ct; first_key = k_first; last_key = k_last;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after start", 64'(busy_o), 64'd1);
    chk("R7 found cleared", 64'(found_o), 64'd0);
    chk("R7 exhausted cleared", 64'(exhausted_o), 64'd0);
    if (disturb) begin
      // R8/R9: new data and a start pulse mid-search must be ignored
      repeat (20) @(negedge clk);
      plain = 64'd0; cipher = CT_ZERO; first_key = 56'd0; last_key = 56'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (sb_q.size() != 0);
    repeat (6) @(negedge clk);
    chk("R7 found held", 64'(found_o), 64'(exp_found));
    chk("R7 exhausted held", 64'(exhausted_o), 64'(!exp_found));
    chk("R7 key held", 64'(key_o), 64'(exp_key));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 64'(busy_o), 64'd0);
    chk("R1 found", 64'(found_o), 64'd0);
    chk("R1 exhausted", 64'(exhausted_o), 64'd0);
    chk("R1 key", 64'(key_o), 64'd0);

    // R2 known answer, single candidate
    run_search(64'h0123456789ABCDEF, 64'h85E813540F0AB405, KEY_A, KEY_A,
               1'b1, KEY_A, 1, "R2", 1'b0);
    // R4 R5 match on fourth ascending candidate, range continues past it
    run_search(64'h0123456789ABCDEF, 64'h85E813540F0AB405, KEY_A - 56'd3, KEY_A + 56'd5,
               1'b1, KEY_A, 4, "R5", 1'b0);
    // R6 match exactly on the last key of the range
    run_search(64'h8787878787878787, 64'h0000000000000000, KEY_B - 56'd2, KEY_B,
               1'b1, KEY_B, 3, "R6", 1'b0);
    // R4 wrap from all ones through zero
    run_search(64'd0, CT_ZERO, 56'hFFFFFFFFFFFFFE, 56'd3,
               1'b1, 56'd0, 3, "R4", 1'b0);
    // R2 all-ones key and block
    run_search(64'hFFFFFFFFFFFFFFFF, 64'h7359B2163E4EDC58, 56'hFFFFFFFFFFFFFF,
               56'hFFFFFFFFFFFFFF, 1'b1, 56'hFFFFFFFFFFFFFF, 1, "R2", 1'b0);
    // R6 single-key range that fails
    run_search(64'd0, CT_ZERO, 56'd5, 56'd5, 1'b0, 56'd5, 1, "R6", 1'b0);
    // R8 R9 exhausted range, disturbed mid-search
    run_search(64'd0, CT_ZERO, 56'd1, 56'd4, 1'b0, 56'd4, 4, "R8", 1'b1);
    // R10 flags after a found following an exhausted
    run_search(64'd0, CT_ZERO, 56'd0, 56'd2, 1'b1, 56'd0, 1, "R10", 1'b0);
    chk("R10 flags exclusive", 64'(found_o & exhausted_o), 64'd0);

    finish_run();
  end

endmodule